// File: doc/BRIEF.md
# Strobe-Captured Byte to Serial Line Bridge

This block takes bytes from a free-running parallel source and sends them out as asynchronous serial frames on one transmit line. There is no handshake on either side. The source is switched on by a run-enable output. It announces each byte by pulling its valid strobe from high to low. The bridge brings the strobe and the eight data lines into the local clock domain and samples the byte on the detected falling edge. It then stores the byte in a small queue. A transmitter drains the queue at a fixed bit rate. The default divider gives 300 baud from a 125 MHz clock.

The serial side has no flow control, so the bridge limits the source through its run-enable output. When the queue reaches an upper fill level, run-enable drops. It returns only after the queue has drained to a lower level. A source that keeps strobing while disabled can still fill the queue. Any byte that arrives while the queue is full is discarded, and a flag records the loss. The flag stays set until reset.

Top module: `strobe_uart_bridge`

## Requirements
- R1: `run_o` is low on the cycle after any cycle in which `enable_i` is low. With `enable_i` high and no throttling in force, `run_o` is high.
- R2: Only a high-to-low change of the synchronised `dav_i` captures a byte. A rising edge, a steady level, or a change on `data_i` while `dav_i` stays high queues nothing.
- R3: Each frame is one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). Every bit lasts `CLKS_PER_BIT` clock cycles. `tx_o` rests at 1 between frames.
- R4: Bytes leave in the order they were captured. Each captured value is transmitted unchanged.
- R5: A byte captured while the queue holds `FIFO_DEPTH` entries is discarded and never transmitted. It sets `overflow_o`, which stays high until reset.
- R6: `run_o` goes low on the cycle after the queue occupancy is at or above `STOP_LEVEL`. It stays low while the occupancy is above `RESUME_LEVEL`, and returns high once the occupancy is at or below `RESUME_LEVEL`.
- R7: `busy_o` is high while the queue holds a byte or a frame is being sent, and low otherwise. When `busy_o` is low, `tx_o` is 1.
- R8: While reset is held, `tx_o` is 1 and `run_o`, `overflow_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Request to run the source |
| dav_i | input | 1 | Asynchronous data-valid strobe, valid on falling edge |
| data_i | input | 8 | Asynchronous parallel data byte |
| run_o | output | 1 | Enable for the data source |
| tx_o | output | 1 | Serial transmit line, idles high |
| overflow_o | output | 1 | Sticky flag: a byte was dropped |
| busy_o | output | 1 | Queue not empty or frame in progress |

## Verification
The hardest state to reach is a full queue with more strobes still arriving. A well-behaved source stops when `run_o` falls, so the queue would never fill. The stimulus therefore acts as a source that ignores `run_o`. It fires a burst of strobes, spaced much closer than one frame, which fills the queue and pushes one byte past its limit. The received frames are then checked against the burst, the dropped byte must never appear, and `run_o` is sampled at each stop bit as the queue drains so the hysteresis between the two levels is observed.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int BYTE_W     = 8;
    localparam int FRAME_BITS = BYTE_W + 2;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_phase_e;

endpackage

// File: rtl/strobe_capture.sv
module strobe_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              dav_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              push_o,
    output logic [DATA_W-1:0] byte_o
);

    typedef struct packed {
        logic              dav_meta;
        logic              dav_sync;
        logic              dav_prev;
        logic [DATA_W-1:0] data_meta;
        logic [DATA_W-1:0] data_sync;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.dav_meta  = dav_i;
        st_d.dav_sync  = st_q.dav_meta;
        st_d.dav_prev  = st_q.dav_sync;
        st_d.data_meta = data_i;
        st_d.data_sync = st_q.data_meta;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.dav_meta  <= 1'b1;
            st_q.dav_sync  <= 1'b1;
            st_q.dav_prev  <= 1'b1;
            st_q.data_meta <= '0;
            st_q.data_sync <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push_o = st_q.dav_prev & ~st_q.dav_sync;
    assign byte_o = st_q.data_sync;

    AST_SINGLE_PUSH_PER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        push_o |=> !push_o) else $error("double capture"); // R2

endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] rdata_o,
    output logic             full_o,
    output logic             empty_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    assign full_o  = (st_q.count == CW'(DEPTH));
    assign empty_o = (st_q.count == '0);
    assign do_push = push_i & ~full_o;
    assign do_pop  = pop_i & ~empty_o;

    always_comb begin
        st_d = st_q;
        if (do_push) begin
            st_d.wptr = (st_q.wptr == LAST_IDX) ? '0 : st_q.wptr + 1'b1;
        end
        if (do_pop) begin
            st_d.rptr = (st_q.rptr == LAST_IDX) ? '0 : st_q.rptr + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (do_push) begin
            mem_q[st_q.wptr] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[st_q.rptr];
    assign level_o = st_q.count;

    AST_FULL_REJECTS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (push_i && full_o && !pop_i) |=> (level_o == $past(level_o))) else $error("write into full queue"); // R5
    AST_LEVEL_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        level_o <= CW'(DEPTH)) else $error("occupancy beyond depth"); // R5

endmodule

// File: rtl/serial_tx.sv
module serial_tx
    import bridge_pkg::*;
#(
    parameter int CLKS_PER_BIT = 416667
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              ready_o,
    output logic              tx_o
);

    localparam int TW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [TW-1:0] TICK_LAST = TW'(CLKS_PER_BIT - 1);
    localparam logic [3:0] BITS_AFTER_START = 4'(FRAME_BITS - 1);

    typedef struct packed {
        tx_phase_e     phase;
        logic [BYTE_W:0] shreg;
        logic [3:0]    bits_left;
        logic [TW-1:0] tick;
        logic          line;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            TX_IDLE: begin
                st_d.line = 1'b1;
                if (load_i) begin
                    st_d.phase     = TX_SEND;
                    st_d.shreg     = {1'b1, byte_i};
                    st_d.bits_left = BITS_AFTER_START;
                    st_d.tick      = '0;
                    st_d.line      = 1'b0;
                end
            end
            TX_SEND: begin
                if (st_q.tick == TICK_LAST) begin
                    st_d.tick = '0;
                    if (st_q.bits_left == '0) begin
                        st_d.phase = TX_IDLE;
                        st_d.line  = 1'b1;
                    end else begin
                        st_d.line      = st_q.shreg[0];
                        st_d.shreg     = {1'b1, st_q.shreg[BYTE_W:1]};
                        st_d.bits_left = st_q.bits_left - 1'b1;
                    end
                end else begin
                    st_d.tick = st_q.tick + 1'b1;
                end
            end
            default: st_d.phase = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.phase     <= TX_IDLE;
            st_q.shreg     <= '1;
            st_q.bits_left <= '0;
            st_q.tick      <= '0;
            st_q.line      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready_o = (st_q.phase == TX_IDLE);
    assign tx_o    = st_q.line;

    AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && ready_o) |=> !tx_o) else $error("start bit not low"); // R3
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ready_o && $past(ready_o)) |-> tx_o) else $error("idle line not high"); // R3

endmodule

// File: rtl/strobe_uart_bridge.sv
module strobe_uart_bridge
    import bridge_pkg::*;
#(
    parameter int CLKS_PER_BIT = 416667,
    parameter int FIFO_DEPTH   = 8,
    parameter int STOP_LEVEL   = 6,
    parameter int RESUME_LEVEL = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic       dav_i,
    input  logic [7:0] data_i,
    output logic       run_o,
    output logic       tx_o,
    output logic       overflow_o,
    output logic       busy_o
);

    localparam int LW = $clog2(FIFO_DEPTH + 1);
    localparam logic [LW-1:0] STOP_AT   = LW'(STOP_LEVEL);
    localparam logic [LW-1:0] RESUME_AT = LW'(RESUME_LEVEL);

    typedef struct packed {
        logic throttle;
        logic run;
        logic overflow;
    } flow_state_t;

    flow_state_t st_d, st_q;

    logic              cap_push;
    logic [BYTE_W-1:0] cap_byte;
    logic [BYTE_W-1:0] head_byte;
    logic              q_full, q_empty;
    logic [LW-1:0]     q_level;
    logic              tx_ready;
    logic              tx_load;

    strobe_capture #(.DATA_W(BYTE_W)) u_capture (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .dav_i  (dav_i),
        .data_i (data_i),
        .push_o (cap_push),
        .byte_o (cap_byte)
    );

    byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_queue (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (cap_push),
        .wdata_i (cap_byte),
        .pop_i   (tx_load),
        .rdata_o (head_byte),
        .full_o  (q_full),
        .empty_o (q_empty),
        .level_o (q_level)
    );

    assign tx_load = tx_ready & ~q_empty;

    serial_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (tx_load),
        .byte_i  (head_byte),
        .ready_o (tx_ready),
        .tx_o    (tx_o)
    );

    always_comb begin
        st_d = st_q;
        if (q_level >= STOP_AT) begin
            st_d.throttle = 1'b1;
        end else if (q_level <= RESUME_AT) begin
            st_d.throttle = 1'b0;
        end
        st_d.run      = enable_i & ~st_d.throttle;
        st_d.overflow = st_q.overflow | (cap_push & q_full);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run_o      = st_q.run;
    assign overflow_o = st_q.overflow;
    assign busy_o     = ~q_empty | ~tx_ready;

    AST_RUN_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> !run_o) else $error("run while disabled"); // R1
    AST_RUN_OFF_AT_HIGH_WATER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_level >= STOP_AT) |=> !run_o) else $error("run at high water"); // R6
    AST_OVERFLOW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overflow_o |=> overflow_o) else $error("overflow flag cleared"); // R5
    AST_QUIET_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> tx_o) else $error("line low while not busy"); // R7

endmodule

// File: tb/strobe_uart_bridge_bench.sv
module strobe_uart_bridge_bench;

    localparam int CPB    = 8;
    localparam int DEPTH  = 4;
    localparam int STOPL  = 3;
    localparam int RESUME = 1;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       enable;
    logic       dav;
    logic [7:0] data;
    logic       run, tx, ovf, busy;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    logic [7:0] got_byte  [8];
    bit         got_ok    [8];
    bit         got_run   [8];

    always #4 clk = ~clk;

    strobe_uart_bridge #(
        .CLKS_PER_BIT (CPB),
        .FIFO_DEPTH   (DEPTH),
        .STOP_LEVEL   (STOPL),
        .RESUME_LEVEL (RESUME)
    ) u_strobe_uart_bridge (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .enable_i   (enable),
        .dav_i      (dav),
        .data_i     (data),
        .run_o      (run),
        .tx_o       (tx),
        .overflow_o (ovf),
        .busy_o     (busy)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
            summary();
            $finish;
        end
    end

    task automatic pulse(input logic [7:0] v);
        data = v;
        repeat (3) @(negedge clk);
        dav = 1'b0;
        repeat (3) @(negedge clk);
        dav = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic rx_frame(output logic [7:0] v, output bit ok, output bit run_at_stop);
        bit seen = 1'b0;
        logic start_b, stop_b;
        v = '0;
        ok = 1'b0;
        run_at_stop = 1'b0;
        for (int w = 0; w < 4000 && !seen; w++) begin
            @(negedge clk);
            if (tx == 1'b0) seen = 1'b1;
        end
        if (!seen) return;
        repeat (CPB / 2) @(negedge clk);
        start_b = tx;
        for (int i = 0; i < 8; i++) begin
            repeat (CPB) @(negedge clk);
            v[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        stop_b = tx;
        run_at_stop = run;
        ok = (start_b == 1'b0) && (stop_b == 1'b1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(tx == 1'b1 && run == 1'b0 && ovf == 1'b0 && busy == 1'b0,
              "R8 reset state", {tx, run, ovf, busy}, 4'b1000);
        rst_n = 1'b1;
    endtask

    initial begin
        enable = 1'b0;
        dav    = 1'b1;
        data   = 8'h00;
        do_reset();

        repeat (4) @(negedge clk);
        check(run == 1'b0, "R1 run low while disabled", run, 0);
        enable = 1'b1;
        repeat (4) @(negedge clk);
        check(run == 1'b1, "R1 run high when enabled", run, 1);

        // R2: data changes and a held-high strobe must queue nothing
        for (int k = 0; k < 6; k++) begin
            data = 8'(k * 37);
            repeat (3) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        check(busy == 1'b0 && tx == 1'b1, "R2 no capture without falling strobe", {busy, tx}, 2'b01);

        // R7: busy during a frame, idle afterwards
        fork
            pulse(8'hA5);
            begin
                repeat (20) @(negedge clk);
                check(busy == 1'b1, "R7 busy during frame", busy, 1);
            end
            rx_frame(got_byte[0], got_ok[0], got_run[0]);
        join
        check(got_ok[0] && got_byte[0] == 8'hA5, "R3 single frame", got_byte[0], 8'hA5);
        repeat (12) @(negedge clk);
        check(busy == 1'b0 && tx == 1'b1, "R7 idle after frame", {busy, tx}, 2'b01);

        // R3 R4: every byte value through the frame path
        for (int v = 0; v < 256; v++) begin
            fork
                pulse(8'(v));
                rx_frame(got_byte[1], got_ok[1], got_run[1]);
            join
            check(got_ok[1] && got_byte[1] == 8'(v), "R3 R4 byte sweep", got_byte[1], v);
        end
        repeat (12) @(negedge clk);

        // R5 R6: burst from a source that ignores run
        fork
            begin
                for (int k = 0; k < 6; k++) pulse(8'(8'h30 + k));
                check(run == 1'b0, "R6 run low at high water", run, 0);
            end
            begin
                for (int f = 0; f < 5; f++) rx_frame(got_byte[f], got_ok[f], got_run[f]);
            end
        join
        for (int f = 0; f < 5; f++) begin
            check(got_ok[f] && got_byte[f] == 8'(8'h30 + f), "R4 burst order", got_byte[f], 8'h30 + f);
        end
        check(got_run[2] == 1'b0, "R6 run held low between levels", got_run[2], 0);
        check(got_run[3] == 1'b1, "R6 run back at resume level", got_run[3], 1);
        check(ovf == 1'b1, "R5 overflow set on drop", ovf, 1);
        repeat (40) @(negedge clk);
        check(busy == 1'b0 && tx == 1'b1, "R5 dropped byte never sent", {busy, tx}, 2'b01);

        fork
            pulse(8'h5A);
            rx_frame(got_byte[6], got_ok[6], got_run[6]);
        join
        check(got_ok[6] && got_byte[6] == 8'h5A, "R4 byte after overflow", got_byte[6], 8'h5A);
        check(ovf == 1'b1, "R5 overflow sticky", ovf, 1);

        do_reset();
        repeat (4) @(negedge clk);
        check(ovf == 1'b0, "R5 overflow cleared by reset", ovf, 0);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        check(run == 1'b0, "R1 run drops when disabled", run, 0);

        summary();
        $finish;
    end

endmodule